// File: doc/BRIEF.md
# Port Control-Line Strobe Generator

This block produces the output behaviour of one control line belonging to a peripheral interface adapter port. A processor writes the port's control register and data register over a simple bus that is qualified by the bus enable clock E. The line can then act as a clock for a serial speech decoder. The line has two kinds of behaviour. In manual mode, software sets the line high or low by rewriting the control register, so software sets the pulse width and the timing against the data line on the other port. In automatic strobe mode, each write to the port data register produces a low-going pulse exactly one E period long, with no software timing involved.

All state runs on a free-running system clock. The block finds the edges of E internally. Bus writes are accepted on the falling edge of E while the device is selected. Every change on the line happens on a rising edge of E.

Top module: `pia_ctl_strobe`

## Requirements
- R1: After reset the line is driven high, the output enable is low, and the control register is zero.
- R2: The output enable equals control bit 5 once a control write completes. While bit 5 is 0 (input mode), each E rising edge leaves the line high.
- R3: Mode field (control bits 5..3) 110 drives the line low and 111 drives it high. Each takes effect on the first E rising edge after the control write.
- R4: With mode field 101 and control bit 2 = 1, a write to address 0 (the data register) pulls the line low on the first E rising edge after that write.
- R5: In mode 101 the line returns high on the first E rising edge that follows a complete E cycle during which select was low. It stays low for as long as every E cycle is selected.
- R6: A write to address 0 while control bit 2 = 0 reaches the direction register and produces no strobe.
- R7: A data write made in a mode other than 101 leaves no pending strobe. A later change to mode 101 produces no pulse from that write.
- R8: Register writes are taken only on an E falling edge with select and write both high. The line changes only on E rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than E |
| rst_n | input | 1 | Asynchronous reset, active low |
| e_clk | input | 1 | Bus enable clock E (level) |
| sel | input | 1 | Device select, active high |
| addr | input | 1 | 0 = data/direction register, 1 = control register |
| wr | input | 1 | Write strobe, active high |
| wdata | input | DATA_W | Write data |
| line_out | output | 1 | Control line level |
| line_oe | output | 1 | Control line output enable |

## Verification
The bench uses the default 8-bit data width. It drives E with a period of eight system clocks, so each E edge falls in its own clock cycle and the one-E-period strobe width can be measured in whole E cycles. With this setting the bench can hold the line low across back-to-back selected cycles and return it high after a single deselected cycle. It can also reach the direction-register path and the stale-write path through mode changes.

// File: rtl/pia_ctl_strobe.sv
module pia_ctl_strobe #(
  parameter int DATA_W   = 8,
  parameter int MODE_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_clk,
  input  logic              sel,
  input  logic              addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              line_out,
  output logic              line_oe
);
  localparam int MODE_MSB = MODE_LSB + 2;
  localparam int DDR_BIT  = MODE_LSB - 1;
  localparam logic [2:0] M_STROBE = 3'b101;
  localparam logic [2:0] M_LOW    = 3'b110;
  localparam logic [2:0] M_HIGH   = 3'b111;

  logic [DATA_W-1:0] ctrl_q;
  logic e_q, pend_q, idle_q, line_q;
  logic e_rise, e_fall, bus_wr;
  logic [2:0] mode;

  assign e_rise = e_clk & ~e_q;
  assign e_fall = ~e_clk & e_q;
  assign bus_wr = e_fall & sel & wr;
  assign mode   = ctrl_q[MODE_MSB:MODE_LSB];
  assign line_out = line_q;
  assign line_oe  = ctrl_q[MODE_MSB];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) e_q <= 1'b0;
    else        e_q <= e_clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ctrl_q <= '0;
    else if (bus_wr && addr)
      ctrl_q <= {2'b00, wdata[MODE_MSB:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      idle_q <= 1'b0;
    else if (e_fall)
      idle_q <= ~sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pend_q <= 1'b0;
    else if (e_rise)
      pend_q <= 1'b0;
    else if (bus_wr && !addr && ctrl_q[DDR_BIT] && mode == M_STROBE)
      pend_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      line_q <= 1'b1;
    else if (e_rise) begin
      if (!ctrl_q[MODE_MSB])     line_q <= 1'b1;
      else if (mode == M_LOW)    line_q <= 1'b0;
      else if (mode == M_HIGH)   line_q <= 1'b1;
      else if (mode == M_STROBE) begin
        if (pend_q)      line_q <= 1'b0;
        else if (idle_q) line_q <= 1'b1;
      end
    end

  assert_line_on_e_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q != $past(line_q)) |-> $past(e_rise));
  assert_input_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rise && !line_oe) |=> line_q);
  assert_manual_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rise && line_oe && mode == M_LOW) |=> !line_q);
  assert_manual_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rise && line_oe && mode == M_HIGH) |=> line_q);
  assert_strobe_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rise && mode == M_STROBE && pend_q) |=> !line_q);
  assert_stay_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rise && mode == M_STROBE && !idle_q && !line_q) |=> !line_q);
  assert_ctrl_only_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(e_fall && sel && wr && addr));
endmodule

// File: tb/sim_pia_ctl_strobe.sv
module sim_pia_ctl_strobe;
  logic clk = 1'b0, rst_n = 1'b0, e_clk = 1'b0, sel = 1'b0, addr = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic line_out, line_oe;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pia_ctl_strobe u0 (.clk(clk), .rst_n(rst_n), .e_clk(e_clk), .sel(sel), .addr(addr),
    .wr(wr), .wdata(wdata), .line_out(line_out), .line_oe(line_oe));

  // {sel, addr, wr, wdata[7:0], exp_line, exp_oe}
  localparam int NV = 23;
  localparam logic [12:0] VEC [NV] = '{
    {3'b111, 8'h2C, 2'b11},  // R2 enter strobe mode, oe high
    {3'b000, 8'h00, 2'b11},  // R5 idle stays high
    {3'b101, 8'h55, 2'b11},  // R4 data write, not yet
    {3'b000, 8'h00, 2'b01},  // R4 low on next E rise
    {3'b000, 8'h00, 2'b11},  // R5 high after deselected cycle
    {3'b101, 8'h00, 2'b11},  // R4 write
    {3'b101, 8'h00, 2'b01},  // R4 second write, low
    {3'b100, 8'h00, 2'b01},  // R5 selected cycle keeps low
    {3'b100, 8'h00, 2'b01},  // R5 still selected previously
    {3'b000, 8'h00, 2'b01},  // R5 previous cycle selected
    {3'b000, 8'h00, 2'b11},  // R5 back high
    {3'b111, 8'h30, 2'b11},  // R3 mode 110 written
    {3'b000, 8'h00, 2'b01},  // R3 low on E rise
    {3'b101, 8'h00, 2'b01},  // R7 data write in manual mode
    {3'b000, 8'h00, 2'b01},  // R7
    {3'b111, 8'h38, 2'b01},  // R3 mode 111 written
    {3'b000, 8'h00, 2'b11},  // R3 high
    {3'b111, 8'hEF, 2'b11},  // R7 switch to 101, no stale pulse
    {3'b000, 8'h00, 2'b11},  // R7 no pulse
    {3'b111, 8'h28, 2'b11},  // R6 select direction register
    {3'b101, 8'hFF, 2'b11},  // R6 direction write
    {3'b000, 8'h00, 2'b11},  // R6 no strobe
    {3'b111, 8'h00, 2'b10}   // R2 input mode, oe low
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic ecyc(input logic s, input logic a, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = s; addr = a; wr = w; wdata = d;
    e_clk = 1'b1;
    repeat (4) @(negedge clk);
    e_clk = 1'b0;
    repeat (4) @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset line", line_out, 1'b1);
    chk("R1 reset oe", line_oe, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ecyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1 idle after reset", line_out, 1'b1);

    for (int i = 0; i < NV; i++) begin
      ecyc(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:2]);
      chk($sformatf("vec%0d line", i), line_out, VEC[i][1]);
      chk($sformatf("vec%0d oe", i), line_oe, VEC[i][0]);
    end

    // R8: a write without E edges does nothing
    @(negedge clk);
    sel = 1'b1; addr = 1'b1; wr = 1'b1; wdata = 8'h30;
    repeat (10) @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    chk("R8 no E no write oe", line_oe, 1'b0);
    ecyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R8 no E no write line", line_out, 1'b1);

    // R8: write with wr low ignored
    ecyc(1'b1, 1'b1, 1'b0, 8'h30);
    chk("R8 wr low ignored", line_oe, 1'b0);

    // R1: reset in mid strobe
    ecyc(1'b1, 1'b1, 1'b1, 8'h2C);
    ecyc(1'b1, 1'b0, 1'b1, 8'h00);
    ecyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R4 low before reset", line_out, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid strobe line", line_out, 1'b1);
    chk("R1 reset mid strobe oe", line_oe, 1'b0);
    rst_n = 1'b1;
    ecyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1 control cleared", line_oe, 1'b0);
    ecyc(1'b1, 1'b0, 1'b1, 8'h00);
    ecyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7 write in input mode no strobe", line_out, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule